// File: doc/BRIEF.md
# Graphics Pixel Unpacker and Depth Expander

This block sits between a memory fetch stream and an overlay blender. It takes 64-bit words that carry packed graphics pixels, cuts each word into its pixels, and turns every pixel into one 32-bit value with alpha, red, green and blue bytes, with alpha in the top byte. Six stored layouts are handled: three 16-bit ones, two 32-bit ones that differ only in where alpha sits, and a 24-bit one with no alpha. Colour fields narrower than 8 bits are widened either by padding with zeros or by repeating their top bits, as picked by a mode pin.

Both stream edges are valid/ready. A word is taken on a cycle where `in_valid` and `in_ready` are both high. `in_ready` stays low while the block still holds a whole pixel that is not leaving in the current cycle. When the last whole pixel of a word leaves, the next word may be taken in the same cycle, so a continuous stream gives one pixel per cycle. A pixel is passed on a cycle where `out_valid` and `out_ready` are both high. `out_valid` and `out_pixel` do not change while the consumer stalls. The format and mode pins may change only while the block holds no data. A run of 24-bit pixels must be a whole number of groups of three words (eight pixels), so that no stray bytes are left behind.

Top module: `gfx_pixel_expander`

## Requirements
- R1: Format code 0 (16-bit, A in bits 15:12, R in 11:8, G in 7:4, B in 3:0): alpha is widened by repeating the nibble in both halves, whatever the mode. Colours follow the mode.
- R2: Format code 1 (16-bit, R in bits 15:11, G in 10:5, B in 4:0): output alpha is 0xFF.
- R3: Format code 2 (16-bit, A in bit 15, R in 14:10, G in 9:5, B in 4:0): output alpha is 0x00 when bit 15 is 0 and 0xFF when it is 1.
- R4: Format code 3 (32-bit, A in bits 31:24, R in 23:16, G in 15:8, B in 7:0) passes through unchanged. Codes 6 and 7 behave the same way.
- R5: Format code 4 (32-bit, R in bits 31:24, G in 23:16, B in 15:8, A in 7:0) is reordered so that alpha lands in output bits 31:24.
- R6: Format code 5 (24-bit, R in bits 23:16, G in 15:8, B in 7:0): pixels take three consecutive bytes of the stream, counted from the least significant byte of each word. They may straddle two words. Output alpha is 0xFF.
- R7: With `exp_mode` = 0, a colour field of width w goes to the top w bits of its output byte, and the low bits are zero.
- R8: With `exp_mode` = 1, the low bits are filled by repeating the field's top bits, so a field of all ones gives 0xFF.
- R9: A word gives four 16-bit or two 32-bit pixels, and the least significant pixel comes out first.
- R10: `in_ready` is high exactly when the bytes left after the current cycle's output do not make a whole pixel. With a continuous supply and no stall, one pixel leaves every cycle.
- R11: `out_valid` is high exactly when a whole pixel is held. While `out_ready` is low, `out_valid` and `out_pixel` hold their values.
- R12: During reset and just after it, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 3 | Stored pixel layout code |
| exp_mode | input | 1 | 0: zero-pad narrow fields, 1: repeat top bits |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Block can take a word |
| in_word | input | 64 | Packed pixel word |
| out_valid | output | 1 | Output pixel is valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_pixel | output | 32 | Pixel as A[31:24] R[23:16] G[15:8] B[7:0] |

## Verification
All state sits in a byte buffer and its fill count. A wrong count shows at the ports in the same cycle, because `in_ready` or `out_valid` then disagrees with the byte tally the bench keeps from the words it has sent. A misplaced byte in the buffer shows on the next pixel that leaves. For 24-bit pixels this can be the pixel that straddles two words, two or three pixels later. Faults in field slicing or widening show on the first pixel of the affected format and mode, and the random runs cover every code in both modes.

// File: rtl/pxu_pkg.sv
package pxu_pkg;

  typedef enum logic [2:0] {
    PF_A4R4G4B4  = 3'd0,
    PF_R5G6B5    = 3'd1,
    PF_A1R5G5B5  = 3'd2,
    PF_A8R8G8B8  = 3'd3,
    PF_R8G8B8A8  = 3'd4,
    PF_R8G8B8    = 3'd5
  } pix_fmt_e;

  // stored bytes per pixel for a layout code; unknown codes act as 32-bit
  function automatic logic [2:0] fmt_bytes(input logic [2:0] code);
    case (code)
      PF_A4R4G4B4, PF_R5G6B5, PF_A1R5G5B5: fmt_bytes = 3'd2;
      PF_R8G8B8:                           fmt_bytes = 3'd3;
      default:                             fmt_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pxu_chan_expand.sv
module pxu_chan_expand #(
  parameter int W = 5
) (
  input  logic [W-1:0] v,
  input  logic         rep,
  output logic [7:0]   y
);
  localparam int PAD = 8 - W;

  for (genvar i = 0; i < 8; i++) begin : g_bit
    if (i >= PAD) begin : g_field
      assign y[i] = v[i-PAD];
    end else begin : g_fill
      assign y[i] = rep & v[W-1-((7-i)%W)];
    end
  end

endmodule

// File: rtl/pxu_unpack.sv
module pxu_unpack
  import pxu_pkg::*;
(
  input  logic [31:0] head,
  input  logic [2:0]  fmt,
  input  logic        rep,
  output logic [31:0] pix
);
  // 4-bit channels: index 3 is alpha, always replicated
  logic [3:0][7:0] n4;
  for (genvar k = 0; k < 4; k++) begin : g_nib
    pxu_chan_expand #(.W(4)) u_x (
      .v   (head[4*k+3 -: 4]),
      .rep ((k == 3) ? 1'b1 : rep),
      .y   (n4[k])
    );
  end

  logic [7:0] r565, g565, b565;
  pxu_chan_expand #(.W(5)) u_r565 (.v(head[15:11]), .rep(rep), .y(r565));
  pxu_chan_expand #(.W(6)) u_g565 (.v(head[10:5]),  .rep(rep), .y(g565));
  pxu_chan_expand #(.W(5)) u_b565 (.v(head[4:0]),   .rep(rep), .y(b565));

  logic [7:0] a555, r555, g555, b555;
  pxu_chan_expand #(.W(1)) u_a555 (.v(head[15]),    .rep(1'b1), .y(a555));
  pxu_chan_expand #(.W(5)) u_r555 (.v(head[14:10]), .rep(rep),  .y(r555));
  pxu_chan_expand #(.W(5)) u_g555 (.v(head[9:5]),   .rep(rep),  .y(g555));
  pxu_chan_expand #(.W(5)) u_b555 (.v(head[4:0]),   .rep(rep),  .y(b555));

  always_comb begin
    case (fmt)
      PF_A4R4G4B4: pix = {n4[3], n4[2], n4[1], n4[0]};
      PF_R5G6B5:   pix = {8'hFF, r565, g565, b565};
      PF_A1R5G5B5: pix = {a555, r555, g555, b555};
      PF_R8G8B8A8: pix = {head[7:0], head[31:8]};
      PF_R8G8B8:   pix = {8'hFF, head[23:0]};
      default:     pix = head;
    endcase
  end

  // R8
  always_comb begin
    if (rep && fmt == PF_R5G6B5 && head[15:0] == 16'hFFFF) begin
      fullscale_chk: assert (pix == 32'hFFFF_FFFF);
    end
  end

endmodule

// File: rtl/pxu_byte_buf.sv
module pxu_byte_buf #(
  parameter int WORD_BYTES = 8,
  parameter int SLOT_BYTES = 12,
  parameter int HEAD_BYTES = 4,
  parameter int CNT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [WORD_BYTES*8-1:0] push_data,
  input  logic                    pop,
  input  logic [2:0]              pop_bytes,
  output logic [HEAD_BYTES*8-1:0] head,
  output logic [CNT_W-1:0]        count,
  output logic [CNT_W-1:0]        count_ap
);
  localparam int BUF_W = SLOT_BYTES * 8;

  logic [BUF_W-1:0] data_q, data_d, kept, ins;
  logic [CNT_W-1:0] cnt_q, cnt_d, drop;

  always_comb begin
    drop     = pop ? CNT_W'(pop_bytes) : '0;
    count_ap = cnt_q - drop;
    kept     = data_q >> {drop, 3'b000};
    ins      = BUF_W'(push_data) << {count_ap, 3'b000};
    data_d   = push ? (kept | ins) : kept;
    cnt_d    = count_ap + (push ? CNT_W'(WORD_BYTES) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      data_q <= data_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = data_q[HEAD_BYTES*8-1:0];
  assign count = cnt_q;

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(SLOT_BYTES));

  // R11
  pop_within_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (CNT_W'(pop_bytes) <= cnt_q));

  // R6
  clean_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q >> {cnt_q, 3'b000}) == '0);

endmodule

// File: rtl/gfx_pixel_expander.sv
module gfx_pixel_expander
  import pxu_pkg::*;
#(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        fmt_sel,
  input  logic              exp_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_pixel
);
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int HEAD_BYTES = 4;
  localparam int SLOT_BYTES = WORD_BYTES + HEAD_BYTES;
  localparam int CNT_W      = $clog2(SLOT_BYTES + 1);

  logic [2:0]              bpp;
  logic [CNT_W-1:0]        count, count_ap;
  logic [HEAD_BYTES*8-1:0] head;
  logic                    out_fire, in_fire;

  assign bpp       = fmt_bytes(fmt_sel);
  assign out_valid = count >= CNT_W'(bpp);
  assign out_fire  = out_valid & out_ready;
  assign in_ready  = count_ap < CNT_W'(bpp);
  assign in_fire   = in_valid & in_ready;

  pxu_byte_buf #(
    .WORD_BYTES (WORD_BYTES),
    .SLOT_BYTES (SLOT_BYTES),
    .HEAD_BYTES (HEAD_BYTES),
    .CNT_W      (CNT_W)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_fire),
    .push_data (in_word),
    .pop       (out_fire),
    .pop_bytes (bpp),
    .head      (head),
    .count     (count),
    .count_ap  (count_ap)
  );

  pxu_unpack u_unpack (
    .head (head),
    .fmt  (fmt_sel),
    .rep  (exp_mode),
    .pix  (out_pixel)
  );

  // R10
  stall_blocks_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  accept_gives_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || fmt_sel != $past(fmt_sel)));

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (fmt_sel != $past(fmt_sel) || exp_mode != $past(exp_mode) ||
       (out_valid && out_pixel == $past(out_pixel))));

  // R3
  alpha_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_sel == PF_A1R5G5B5) |->
      (out_pixel[31:24] == 8'h00 || out_pixel[31:24] == 8'hFF));

  // R2 R6
  opaque_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (fmt_sel == PF_R5G6B5 || fmt_sel == PF_R8G8B8)) |->
      out_pixel[31:24] == 8'hFF);

  // R1
  alpha_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && fmt_sel == PF_A4R4G4B4) |->
      out_pixel[31:28] == out_pixel[27:24]);

endmodule

// File: tb/sim_gfx_pixel_expander.sv
module sim_gfx_pixel_expander;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = 3'd0;
  logic        exp_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_pixel;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;
  logic [7:0]  mq[$];
  logic [31:0] seen[$];

  gfx_pixel_expander u0 (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .exp_mode(exp_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      n_checks = n_checks + 1;
      n_fails  = n_fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] f);
    if (f <= 3'd2) return 2;
    if (f == 3'd5) return 3;
    return 4;
  endfunction

  function automatic string tag_of(input logic [2:0] f);
    case (f)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd4: return "R5";
      3'd5: return "R6";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [7:0] wide(input int v, input int w, input logic m);
    int r;
    r = v << (8 - w);
    if (m) begin
      if (w == 4) r = v * 17;
      else if (w == 5) r = (v << 3) | (v >> 2);
      else if (w == 6) r = (v << 2) | (v >> 4);
    end
    return r[7:0];
  endfunction

  function automatic logic [31:0] model_pix(input logic [2:0] f, input logic m, input logic [31:0] p);
    logic [7:0] a, r, g, b;
    case (f)
      3'd0: begin
        a = wide(int'(p[15:12]), 4, 1'b1); r = wide(int'(p[11:8]), 4, m);
        g = wide(int'(p[7:4]), 4, m);      b = wide(int'(p[3:0]), 4, m);
      end
      3'd1: begin
        a = 8'hFF; r = wide(int'(p[15:11]), 5, m);
        g = wide(int'(p[10:5]), 6, m); b = wide(int'(p[4:0]), 5, m);
      end
      3'd2: begin
        a = p[15] ? 8'hFF : 8'h00; r = wide(int'(p[14:10]), 5, m);
        g = wide(int'(p[9:5]), 5, m); b = wide(int'(p[4:0]), 5, m);
      end
      3'd4: begin a = p[7:0]; r = p[31:24]; g = p[23:16]; b = p[15:8]; end
      3'd5: begin a = 8'hFF; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
      default: begin a = p[31:24]; r = p[23:16]; g = p[15:8]; b = p[7:0]; end
    endcase
    return {a, r, g, b};
  endfunction

  // one cycle: drive at negedge, judge settled outputs before the next edge
  task automatic step(input bit iv, input logic [63:0] w, input bit ordy, output bit acc);
    int  nb;
    bit  fire;
    logic [31:0] p;
    @(negedge clk);
    in_valid  = iv;
    in_word   = w;
    out_ready = ordy;
    #1;
    nb   = nbytes(fmt_sel);
    fire = 1'b0;
    check("R11 out_valid", {31'd0, out_valid}, {31'd0, (mq.size() >= nb)});
    if (mq.size() >= nb && ordy) fire = 1'b1;
    check("R10 in_ready", {31'd0, in_ready},
          {31'd0, ((mq.size() - (fire ? nb : 0)) < nb)});
    if (out_valid && ordy && mq.size() >= nb) begin
      p = '0;
      for (int i = 0; i < nb; i++) p[8*i +: 8] = mq[i];
      check(tag_of(fmt_sel), out_pixel, model_pix(fmt_sel, exp_mode, p));
      for (int i = 0; i < nb; i++) void'(mq.pop_front());
      seen.push_back(out_pixel);
    end
    acc = 1'b0;
    if (iv && in_ready) begin
      for (int i = 0; i < 8; i++) mq.push_back(w[8*i +: 8]);
      acc = 1'b1;
    end
  endtask

  task automatic drain();
    bit acc;
    while (mq.size() > 0) step(1'b0, '0, 1'b1, acc);
    step(1'b0, '0, 1'b1, acc);
  endtask

  task automatic set_fmt(input logic [2:0] f, input logic m);
    @(negedge clk);
    fmt_sel  = f;
    exp_mode = m;
    seen.delete();
  endtask

  task automatic send(input logic [63:0] w);
    bit acc;
    acc = 1'b0;
    while (!acc) step(1'b1, w, 1'b1, acc);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    bit acc;
    int fires;
    logic [31:0] held;
    void'($urandom(32'h5EED_0042));

    // R12: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R12 out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R12 in_ready in reset",  {31'd0, in_ready},  32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R12 in_ready after reset",  {31'd0, in_ready},  32'd1);

    // R9: least significant pixel first
    set_fmt(3'd0, 1'b0);
    send(64'h4444_3333_2222_1111);
    drain();
    check("R9 first pixel",  seen[0], 32'h1110_1010);
    check("R9 fourth pixel", seen[3], 32'h4440_4040);

    // R8 / R7: full-scale 5-6-5 in both modes
    set_fmt(3'd1, 1'b1);
    send('1);
    drain();
    check("R8 full scale repeat", seen[0], 32'hFFFF_FFFF);
    set_fmt(3'd1, 1'b0);
    send('1);
    drain();
    check("R7 full scale zero pad", seen[0], 32'hFFF8_FCF8);

    // R3: one-bit alpha
    set_fmt(3'd2, 1'b0);
    send(64'h0000_0000_7FFF_8000);
    drain();
    check("R3 alpha set",   seen[0], 32'hFF00_0000);
    check("R3 alpha clear", seen[1], 32'h00F8_F8F8);

    // R5: alpha-last reorder
    set_fmt(3'd4, 1'b0);
    send(64'h5566_7788_1122_3344);
    drain();
    check("R5 reorder", seen[0], 32'h4411_2233);

    // R6: straddling 24-bit pixel
    set_fmt(3'd5, 1'b0);
    send(64'h0706_0504_0302_0100);
    send(64'h0F0E_0D0C_0B0A_0908);
    send(64'h1716_1514_1312_1110);
    drain();
    check("R6 first pixel",      seen[0], 32'hFF02_0100);
    check("R6 straddling pixel", seen[2], 32'hFF08_0706);

    // R11: stall holds output, R10: stall blocks input
    set_fmt(3'd3, 1'b0);
    step(1'b1, 64'hA1B2_C3D4_E5F6_0718, 1'b0, acc);
    step(1'b0, '0, 1'b0, acc);
    held = out_pixel;
    for (int i = 0; i < 3; i++) begin
      step(1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, acc);
      check("R11 held valid", {31'd0, out_valid}, 32'd1);
      check("R11 held pixel", out_pixel, held);
      check("R10 input blocked", {31'd0, acc}, 32'd0);
    end
    drain();

    // R10: full throughput on a continuous stream
    set_fmt(3'd0, 1'b1);
    fires = 0;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, rnd64(), 1'b1, acc);
    end
    fires = seen.size();
    check("R10 one pixel per cycle", fires, 39);
    drain();

    // random runs over all codes and both modes
    for (int run = 0; run < 80; run++) begin
      logic [2:0]  f;
      logic [63:0] w;
      int nw, sent;
      f = 3'($urandom_range(0, 7));
      set_fmt(f, 1'($urandom_range(0, 1)));
      nw = (f == 3'd5) ? 3 * $urandom_range(1, 3) : $urandom_range(1, 6);
      sent = 0;
      w = rnd64();
      while (sent < nw) begin
        step(($urandom_range(0, 3) != 0), w, ($urandom_range(0, 3) != 0), acc);
        if (acc) begin
          sent++;
          w = rnd64();
        end
      end
      drain();
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

endmodule